// File: doc/BRIEF.md
# Decimal Digit-Serial Adder

This block adds two unsigned decimal numbers of any length, one digit position per clock cycle. On every cycle flagged as valid it takes one BCD digit of each operand and returns the BCD digit of the sum for that position in the same cycle. Digits are fed lowest position first. The only state carried from one position to the next is a single decimal carry bit, held in one register.

A caller marks the lowest digit of a new operand pair with the start strobe. That digit then sees a carry-in of zero, whatever the previous addition left behind. A start strobe without a valid digit simply clears the carry. After the highest digit the stored carry is the final carry-out, and the caller may append it as one more leading digit. Input codes above nine are flagged. They are still reduced modulo ten, so the datapath never produces an undefined value.

Top module: `bcd_serial_adder`

## Requirements
- R1: While `in_valid_i` is high, `sum_digit_o` equals (a + b + cin) mod 10 in the same cycle, and `sum_valid_o` follows `in_valid_i`. Here a and b are the unsigned 4-bit input codes and cin is the carry-in for the digit.
- R2: At a rising clock edge with `in_valid_i` high, the stored carry becomes 1 when a + b + cin is 10 or more, and 0 otherwise.
- R3: At an edge with both `in_valid_i` and `start_i` low, the stored carry keeps its value, whatever is on the digit inputs.
- R4: With `start_i` high and `in_valid_i` low, the stored carry is 0 after the edge. With both high, the digit uses cin = 0 and the carry then loads from that digit as in R2.
- R5: Driving `rst_n` low clears the stored carry at once, without waiting for a clock edge. Release is synchronised to `clk` through a short flop chain, and digits presented during reset or release are not accumulated.
- R6: `digit_err_o` is high exactly when `in_valid_i` is high and either input code lies in 10..15. Such a digit still gives (a + b + cin) mod 10 on `sum_digit_o` and a carry of (a + b + cin >= 10).
- R7: `carry_o` shows the stored carry. After the last digit of an addition it holds the final carry-out until the next valid digit, start or reset.
- R8: A multi-digit addition fed lowest position first, with start on its first digit, yields the decimal sum digit by digit. For example, 1638753 + 3652425 gives digits 8, 7, 1, 1, 9, 2, 5 and a final carry of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Marks the first digit of a new addition (forces carry-in 0) |
| in_valid_i | input | 1 | Digit inputs carry a digit this cycle |
| a_digit_i | input | 4 | BCD digit of operand A |
| b_digit_i | input | 4 | BCD digit of operand B |
| sum_digit_o | output | 4 | BCD digit of the sum, same cycle |
| sum_valid_o | output | 1 | Sum digit is valid |
| digit_err_o | output | 1 | An input code in 10..15 was seen on a valid cycle |
| carry_o | output | 1 | Stored decimal carry (final carry-out after the last digit) |

## Verification
The bench sweeps every pair of legal digits with both carry-in values. An off-by-one in the decimal correction would give a wrong digit or carry at sums of exactly 9, 10 or 19. It checks a start that coincides with a valid digit: a design that lets the stale carry leak into that digit would give a result one too high. It drops reset mid-addition with the carry set. It also leaves the block idle for several cycles with junk on the digit inputs, where a design that ignores the valid strobe would corrupt the carry. Illegal codes up to 15 + 15 + 1 are also applied. A fold that is too shallow would give a digit above nine, and an ungated error flag would fire on idle cycles.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned RADIX   = 10;
  localparam int unsigned SYNC_N  = 2;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef struct packed {
    digit_t digit;
    logic   carry;
    logic   illegal;
  } digit_res_t;
endpackage

// File: rtl/bcd_rst_sync.sv
module bcd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
  import bcd_add_pkg::*;
#(
  parameter int unsigned W = DIGIT_W,
  parameter int unsigned R = RADIX
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output digit_res_t   res
);
  localparam int unsigned SUM_W = W + 1;
  localparam int unsigned MAXV  = 2 * ((1 << W) - 1) + 1;
  localparam int unsigned FOLDS = MAXV / R;
  localparam logic [SUM_W-1:0] R_V = SUM_W'(R);
  localparam logic [W-1:0]     R_D = W'(R);

  logic [SUM_W-1:0] stage [FOLDS+1];

  // raw binary sum of the two codes and the carry-in
  assign stage[0] = SUM_W'(a) + SUM_W'(b) + SUM_W'(cin);

  // repeated conditional subtraction reduces any code sum to 0..R-1
  for (genvar k = 0; k < FOLDS; k++) begin : g_fold
    assign stage[k+1] = (stage[k] >= R_V) ? (stage[k] - R_V) : stage[k];
  end

  always_comb begin
    res.digit   = W'(stage[FOLDS]);
    res.carry   = (stage[0] >= R_V);
    res.illegal = (a >= R_D) || (b >= R_D);
  end
endmodule

// File: rtl/bcd_carry_reg.sv
module bcd_carry_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic d,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (en)       q_nxt = d;
    else if (clr) q_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/bcd_serial_adder.sv
module bcd_serial_adder
  import bcd_add_pkg::*;
#(
  parameter int unsigned W      = DIGIT_W,
  parameter int unsigned R      = RADIX,
  parameter int unsigned SYNC_STAGES = SYNC_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         in_valid_i,
  input  logic [W-1:0] a_digit_i,
  input  logic [W-1:0] b_digit_i,
  output logic [W-1:0] sum_digit_o,
  output logic         sum_valid_o,
  output logic         digit_err_o,
  output logic         carry_o
);
  logic       rst_sync_n;
  logic       carry_q;
  logic       carry_in;
  digit_res_t res;

  bcd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  // a start strobe makes the current digit the lowest of a new addition
  assign carry_in = start_i ? 1'b0 : carry_q;

  bcd_digit_add #(.W(W), .R(R)) u_add (
    .a   (a_digit_i),
    .b   (b_digit_i),
    .cin (carry_in),
    .res (res)
  );

  bcd_carry_reg u_carry (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (start_i),
    .en    (in_valid_i),
    .d     (res.carry),
    .q     (carry_q)
  );

  assign sum_digit_o = res.digit;
  assign sum_valid_o = in_valid_i;
  assign digit_err_o = in_valid_i & res.illegal;
  assign carry_o     = carry_q;
endmodule

// File: rtl/bcd_serial_adder_chk.sv
module bcd_serial_adder_chk #(
  parameter int unsigned W = 4,
  parameter int unsigned R = 10
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         start_i,
  input logic         in_valid_i,
  input logic [W-1:0] a_digit_i,
  input logic [W-1:0] b_digit_i,
  input logic [W-1:0] sum_digit_o,
  input logic         sum_valid_o,
  input logic         digit_err_o,
  input logic         carry_o
);
  localparam int unsigned SW = W + 2;

  // R1
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    sum_valid_o |-> (sum_digit_o < W'(R)));

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    sum_valid_o == in_valid_i);

  // R2
  carry_set_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid_i && !start_i &&
     (SW'(a_digit_i) + SW'(b_digit_i) + SW'(carry_o) >= SW'(R))) |=> carry_o);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!in_valid_i && !start_i) |=> $stable(carry_o));

  // R4
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (start_i && !in_valid_i) |=> !carry_o);

  // R5
  reset_clear_chk: assert property (@(posedge clk)
    !rst_ok |-> !carry_o);

  // R6
  err_gate_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    digit_err_o |-> in_valid_i);

  // R6
  legal_noerr_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (a_digit_i < W'(R) && b_digit_i < W'(R)) |-> !digit_err_o);
endmodule

bind bcd_serial_adder bcd_serial_adder_chk #(.W(W), .R(R)) u_chk (
  .clk         (clk),
  .rst_ok      (rst_sync_n),
  .start_i     (start_i),
  .in_valid_i  (in_valid_i),
  .a_digit_i   (a_digit_i),
  .b_digit_i   (b_digit_i),
  .sum_digit_o (sum_digit_o),
  .sum_valid_o (sum_valid_o),
  .digit_err_o (digit_err_o),
  .carry_o     (carry_o)
);

// File: tb/bcd_serial_adder_tb.sv
module bcd_serial_adder_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, in_valid_i;
  logic [3:0] a_d, b_d;
  logic [3:0] sum_d;
  logic       sum_v, err, carry;

  int total = 0;
  int bad   = 0;
  int exp_c = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  bcd_serial_adder u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .in_valid_i  (in_valid_i),
    .a_digit_i   (a_d),
    .b_digit_i   (b_d),
    .sum_digit_o (sum_d),
    .sum_valid_o (sum_v),
    .digit_err_o (err),
    .carry_o     (carry)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic s, input int a, input int b);
    @(negedge clk);
    in_valid_i = v; start_i = s; a_d = 4'(a); b_d = 4'(b);
    #2;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // one valid digit, checked against the bench model
  task automatic digit_step(input int a, input int b, input logic s, input string req);
    int cin = s ? 0 : exp_c;
    int tot = a + b + cin;
    drive(1'b1, s, a, b);
    chk(int'(sum_d) == tot % 10, {req, " digit"}, int'(sum_d), tot % 10);
    chk(sum_v == 1'b1, "R1 valid", int'(sum_v), 1);
    chk(int'(err) == int'(a > 9 || b > 9), "R6 err flag", int'(err), int'(a > 9 || b > 9));
    tick();
    exp_c = (tot >= 10) ? 1 : 0;
    chk(int'(carry) == exp_c, "R2 carry", int'(carry), exp_c);
  endtask

  task automatic go_idle();
    drive(1'b0, 1'b0, 0, 0);
  endtask

  task automatic t_reset_start();
    rst_n = 1'b0; start_i = 0; in_valid_i = 0; a_d = 0; b_d = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(carry == 1'b0, "R5 carry in reset", int'(carry), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) tick();
    exp_c = 0;
    chk(carry == 1'b0, "R5 carry after release", int'(carry), 0);
    drive(1'b0, 1'b0, 0, 0);
    chk(sum_v == 1'b0, "R1 valid low when idle", int'(sum_v), 0);
  endtask

  task automatic t_example();
    int a_num[7] = '{3, 5, 7, 8, 3, 6, 1};
    int b_num[7] = '{5, 2, 4, 2, 5, 6, 3};
    int want[7]  = '{8, 7, 1, 1, 9, 2, 5};
    for (int i = 0; i < 7; i++) begin
      drive(1'b1, i == 0, a_num[i], b_num[i]);
      chk(int'(sum_d) == want[i], "R8 example digit", int'(sum_d), want[i]);
      tick();
    end
    exp_c = 0;
    go_idle();
    chk(carry == 1'b0, "R8 final carry", int'(carry), 0);
  endtask

  task automatic t_carry_chain();
    digit_step(9, 1, 1'b1, "R8 chain");
    digit_step(9, 0, 1'b0, "R8 chain");
    digit_step(9, 0, 1'b0, "R8 chain");
    go_idle();
    tick();
    chk(carry == 1'b1, "R7 final carry held", int'(carry), 1);
  endtask

  task automatic t_idle_hold();
    digit_step(7, 6, 1'b1, "R2 setup");
    for (int i = 0; i < 5; i++) begin
      drive(1'b0, 1'b0, 12 + i % 4, 9 - i);
      chk(err == 1'b0, "R6 err gated when idle", int'(err), 0);
      tick();
      chk(carry == 1'b1, "R3 hold on idle", int'(carry), 1);
    end
  endtask

  task automatic t_start();
    digit_step(9, 9, 1'b1, "R4 setup");
    drive(1'b0, 1'b1, 0, 0);
    tick();
    chk(carry == 1'b0, "R4 start alone clears", int'(carry), 0);
    exp_c = 0;
    digit_step(9, 9, 1'b1, "R4 setup");
    digit_step(8, 5, 1'b1, "R4 start with digit");
    digit_step(2, 3, 1'b1, "R4 start ignores stale carry");
    go_idle();
  endtask

  task automatic t_illegal();
    digit_step(12, 0, 1'b1, "R6 illegal");
    digit_step(15, 15, 1'b0, "R6 illegal");
    digit_step(9, 10, 1'b0, "R6 illegal");
    digit_step(0, 11, 1'b1, "R6 illegal");
    go_idle();
  endtask

  task automatic t_sweep();
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 10; a++)
        for (int b = 0; b < 10; b++) begin
          digit_step(c ? 9 : 0, c ? 1 : 0, 1'b1, "R2 prime");
          digit_step(a, b, 1'b0, "R1 sweep");
        end
    go_idle();
  endtask

  task automatic t_reset_mid();
    digit_step(6, 6, 1'b1, "R5 setup");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(carry == 1'b0, "R5 async clear", int'(carry), 0);
    in_valid_i = 1; a_d = 4'd9; b_d = 4'd9;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; in_valid_i = 0;
    repeat (3) tick();
    exp_c = 0;
    chk(carry == 1'b0, "R5 nothing accumulated", int'(carry), 0);
    digit_step(4, 3, 1'b0, "R5 after reset");
    go_idle();
  endtask

  initial begin
    t_reset_start();
    t_example();
    t_carry_chain();
    t_idle_hold();
    t_start();
    t_illegal();
    t_sweep();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule